// File: doc/BRIEF.md
# Receive Message FIFO Index Manager

This block keeps the bookkeeping for one queued receive buffer of a time-triggered fieldbus controller. The queue is a ring of message buffer header slots that sits anywhere inside a shared frame memory. Three runtime settings place and size it: the header index of its first slot, how many slots it has, and how long each slot's data field is. These settings can be changed only while the protocol engine is in its configuration state. A depth below two is rejected as a configuration error, and while that error is present reception stays off.

When a frame ends for a slot that has no dedicated buffer assigned or subscribed, and the acceptance filter passes it, the block appends it. It raises write strobes for the frame header and the slot status, and it gives the header address (start index plus write offset) and the data field address (data base plus write offset times entry size). The host reads the entry at the read index and pops it. A frame that arrives while the ring is full is dropped and sets a sticky overflow flag, which the host clears with a write-one pulse. Each channel uses its own instance, and the instances share nothing.

Top module: `rxq_index_mgr`

## Requirements
- R1: The start, depth and size registers take a write only while `cfg_mode` is 1. A write strobe with `cfg_mode` at 0 leaves the readback ports unchanged.
- R2: `cfg_err` is 1 while the stored depth is below 2. While it is set, no frame is appended: `hdr_we` stays 0 and `entry_cnt` stays 0.
- R3: A frame (`frm_valid`=1) is appended only when `slot_has_mb`=0 and `filt_accept`=1. Any other frame produces no strobe and leaves the count unchanged.
- R4: One clock after an accepted frame is sampled, `hdr_we` and `stat_we` are 1 for one cycle. At that time `hdr_addr` = start + write offset (modulo 2^IDX_W) and `data_addr` = `data_base` + write offset × size (modulo 2^DADDR_W).
- R5: The write and read offsets count from 0 up to depth−1 and then wrap to 0.
- R6: A pop on a non-empty ring advances the read offset by one. `rd_hdr_idx` = start + read offset. A pop on an empty ring changes nothing.
- R7: An accepted frame that arrives while the ring is full gives no strobe and leaves the count unchanged. It sets `overflow` one clock later. `overflow` holds until an `ovf_clr` pulse, and when a new drop and a clear happen in the same cycle, the set wins.
- R8: While `cfg_mode` is 1, both offsets and the count are held at 0 and neither appends nor pops take place. After leaving the state, the first append uses offset 0.
- R9: `empty` is 1 exactly when `entry_cnt` is 0 and `nempty_irq` is its inverse. `full` is 1 when `entry_cnt` equals the depth and the configuration is valid.
- R10: After reset, `entry_cnt`=0, `empty`=1, `overflow`=0, the strobes are 0, the configuration registers are 0 and `cfg_err`=1.
- R11: Two instances keep fully separate state. Activity on one changes no output of the other.
- R12: A pop and an accepted append in the same cycle on a ring that is neither full nor empty advance both offsets and leave `entry_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Protocol engine is in its configuration state |
| cfg_we_start | input | 1 | Write strobe for the start index |
| cfg_we_depth | input | 1 | Write strobe for the depth |
| cfg_we_size | input | 1 | Write strobe for the entry data size |
| cfg_start_in | input | IDX_W | New start header index |
| cfg_depth_in | input | DEPTH_W | New depth |
| cfg_size_in | input | SIZE_W | New entry data size |
| data_base | input | DADDR_W | Base address of the data fields |
| frm_valid | input | 1 | A received frame is complete this cycle |
| slot_has_mb | input | 1 | The frame's slot has a dedicated buffer |
| filt_accept | input | 1 | The acceptance filter passes the frame |
| pop_req | input | 1 | Host pops the entry at the read index |
| ovf_clr | input | 1 | Write-one pulse that clears overflow |
| cfg_start | output | IDX_W | Stored start index |
| cfg_depth | output | DEPTH_W | Stored depth |
| cfg_size | output | SIZE_W | Stored entry data size |
| cfg_err | output | 1 | The stored depth is below 2 |
| hdr_we | output | 1 | Write strobe for the frame header |
| stat_we | output | 1 | Write strobe for the slot status |
| hdr_addr | output | IDX_W | Header index of the slot being written |
| data_addr | output | DADDR_W | Data field address of the slot being written |
| rd_hdr_idx | output | IDX_W | Header index at the read offset |
| entry_cnt | output | DEPTH_W | Number of entries held |
| empty | output | 1 | Ring holds no entry |
| full | output | 1 | Ring holds depth entries |
| nempty_irq | output | 1 | Not-empty interrupt flag |
| overflow | output | 1 | Sticky flag: an accepted frame was dropped |

## Verification
All results are due one clock edge after their stimulus. Configuration readback, `cfg_err`, the offsets, `entry_cnt`, the derived flags and `rd_hdr_idx` change at the edge that samples the write, the frame or the pop. The strobes, both addresses and `overflow` are registered at that same edge, so they become visible one edge after the frame's inputs are sampled. The bench changes inputs on the falling edge and reads every result on the next falling edge, which is exactly one rising edge later. It therefore checks each result in the single cycle in which the result is due.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Smallest depth for which the read offset always names a filled slot
  localparam int unsigned RXQ_MIN_DEPTH = 2;

  // What happens to the frame presented in the current cycle
  typedef enum logic [1:0] {
    RXQ_IDLE,    // no frame, or reception disabled
    RXQ_IGNORE,  // dedicated buffer or filter rejects
    RXQ_DROP,    // accepted but ring is full
    RXQ_STORE    // appended at the write offset
  } rxq_verdict_e;
endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 5,
  parameter int SIZE_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic               we_start,
  input  logic               we_depth,
  input  logic               we_size,
  input  logic [IDX_W-1:0]   start_in,
  input  logic [DEPTH_W-1:0] depth_in,
  input  logic [SIZE_W-1:0]  size_in,
  output logic [IDX_W-1:0]   start_q,
  output logic [DEPTH_W-1:0] depth_q,
  output logic [SIZE_W-1:0]  size_q,
  output logic               err_q
);
  import rxq_pkg::*;

  localparam logic [DEPTH_W-1:0] MinDepth = DEPTH_W'(RXQ_MIN_DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      depth_q <= '0;
      size_q  <= '0;
      err_q   <= 1'b1;
    end else if (cfg_mode) begin
      if (we_start) start_q <= start_in;
      if (we_size)  size_q  <= size_in;
      if (we_depth) begin
        depth_q <= depth_in;
        err_q   <= (depth_in < MinDepth);
      end
    end
  end
endmodule

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] depth,
  output logic [W-1:0] ptr
);
  logic at_last;
  assign at_last = (ptr == depth - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      ptr <= '0;
    else if (adv)
      ptr <= at_last ? '0 : ptr + W'(1);
  end
endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 5,
  parameter int SIZE_W  = 7,
  parameter int DADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               store,
  input  logic [IDX_W-1:0]   start,
  input  logic [DEPTH_W-1:0] wr_ptr,
  input  logic [SIZE_W-1:0]  size,
  input  logic [DADDR_W-1:0] data_base,
  output logic               we,
  output logic [IDX_W-1:0]   hdr_addr,
  output logic [DADDR_W-1:0] data_addr
);
  localparam int PROD_W = DEPTH_W + SIZE_W;

  logic [PROD_W-1:0] byte_off;
  assign byte_off = PROD_W'(wr_ptr) * PROD_W'(size);

  always_ff @(posedge clk) begin
    if (rst) begin
      we        <= 1'b0;
      hdr_addr  <= '0;
      data_addr <= '0;
    end else begin
      we <= store;
      if (store) begin
        hdr_addr  <= start + IDX_W'(wr_ptr);
        data_addr <= data_base + DADDR_W'(byte_off);
      end
    end
  end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 5,
  parameter int SIZE_W  = 7,
  parameter int DADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic               cfg_we_start,
  input  logic               cfg_we_depth,
  input  logic               cfg_we_size,
  input  logic [IDX_W-1:0]   cfg_start_in,
  input  logic [DEPTH_W-1:0] cfg_depth_in,
  input  logic [SIZE_W-1:0]  cfg_size_in,
  input  logic [DADDR_W-1:0] data_base,
  input  logic               frm_valid,
  input  logic               slot_has_mb,
  input  logic               filt_accept,
  input  logic               pop_req,
  input  logic               ovf_clr,
  output logic [IDX_W-1:0]   cfg_start,
  output logic [DEPTH_W-1:0] cfg_depth,
  output logic [SIZE_W-1:0]  cfg_size,
  output logic               cfg_err,
  output logic               hdr_we,
  output logic               stat_we,
  output logic [IDX_W-1:0]   hdr_addr,
  output logic [DADDR_W-1:0] data_addr,
  output logic [IDX_W-1:0]   rd_hdr_idx,
  output logic [DEPTH_W-1:0] entry_cnt,
  output logic               empty,
  output logic               full,
  output logic               nempty_irq,
  output logic               overflow
);
  import rxq_pkg::*;

  logic [DEPTH_W-1:0] wr_ptr, rd_ptr;
  logic               rx_en, store, do_pop, frame_we;
  rxq_verdict_e       verdict;

  rxq_cfg_regs #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .we_start(cfg_we_start), .we_depth(cfg_we_depth), .we_size(cfg_we_size),
    .start_in(cfg_start_in), .depth_in(cfg_depth_in), .size_in(cfg_size_in),
    .start_q(cfg_start), .depth_q(cfg_depth), .size_q(cfg_size), .err_q(cfg_err)
  );

  // Reception runs only outside the configuration state with a legal depth
  assign rx_en = !cfg_mode && !cfg_err;
  assign empty = (entry_cnt == '0);
  assign full  = !cfg_err && (entry_cnt == cfg_depth);
  assign nempty_irq = !empty;

  always_comb begin
    if (!rx_en || !frm_valid)          verdict = RXQ_IDLE;
    else if (slot_has_mb || !filt_accept) verdict = RXQ_IGNORE;
    else if (full)                     verdict = RXQ_DROP;
    else                               verdict = RXQ_STORE;
  end

  assign store  = (verdict == RXQ_STORE);
  assign do_pop = !cfg_mode && pop_req && !empty;

  rxq_ring_ptr #(.W(DEPTH_W)) u_wr (
    .clk(clk), .rst(rst), .clr(cfg_mode), .adv(store), .depth(cfg_depth), .ptr(wr_ptr)
  );

  rxq_ring_ptr #(.W(DEPTH_W)) u_rd (
    .clk(clk), .rst(rst), .clr(cfg_mode), .adv(do_pop), .depth(cfg_depth), .ptr(rd_ptr)
  );

  assign rd_hdr_idx = cfg_start + IDX_W'(rd_ptr);

  always_ff @(posedge clk) begin
    if (rst || cfg_mode)
      entry_cnt <= '0;
    else if (store && !do_pop)
      entry_cnt <= entry_cnt + DEPTH_W'(1);
    else if (do_pop && !store)
      entry_cnt <= entry_cnt - DEPTH_W'(1);
  end

  // Sticky overflow: a new drop wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      overflow <= 1'b0;
    else if (verdict == RXQ_DROP)
      overflow <= 1'b1;
    else if (ovf_clr)
      overflow <= 1'b0;
  end

  rxq_addr_gen #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W), .DADDR_W(DADDR_W)) u_addr (
    .clk(clk), .rst(rst), .store(store), .start(cfg_start), .wr_ptr(wr_ptr),
    .size(cfg_size), .data_base(data_base),
    .we(frame_we), .hdr_addr(hdr_addr), .data_addr(data_addr)
  );

  // Header and slot status go to separate fields of the same entry
  assign hdr_we  = frame_we;
  assign stat_we = frame_we;
endmodule

// File: rtl/rxq_index_mgr_chk.sv
module rxq_index_mgr_chk #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 5,
  parameter int SIZE_W  = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_mode,
  input logic               frm_valid,
  input logic               pop_req,
  input logic               ovf_clr,
  input logic [IDX_W-1:0]   cfg_start,
  input logic [DEPTH_W-1:0] cfg_depth,
  input logic [SIZE_W-1:0]  cfg_size,
  input logic               cfg_err,
  input logic               hdr_we,
  input logic [DEPTH_W-1:0] entry_cnt,
  input logic               empty,
  input logic               full,
  input logic               overflow
);
  // R1: configuration is frozen outside the configuration state
  a_r1_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(cfg_start) && $stable(cfg_depth) && $stable(cfg_size)));

  // R2: an illegal depth blocks appends
  a_r2_no_append_on_err: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !hdr_we);

  // R7: a full ring is never written
  a_r7_full_no_write: assert property (@(posedge clk) disable iff (rst)
    full |=> !hdr_we);

  // R7: overflow stays set until cleared
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  // R6: popping an empty ring leaves it empty
  a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !frm_valid) |=> empty);

  // R8: the configuration state clears the ring and blocks writes
  a_r8_cfg_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> (entry_cnt == '0 && !hdr_we));

  // R9: the count never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    entry_cnt <= cfg_depth);
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(
  .IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .frm_valid(frm_valid),
  .pop_req(pop_req), .ovf_clr(ovf_clr), .cfg_start(cfg_start),
  .cfg_depth(cfg_depth), .cfg_size(cfg_size), .cfg_err(cfg_err),
  .hdr_we(hdr_we), .entry_cnt(entry_cnt), .empty(empty), .full(full),
  .overflow(overflow)
);

// File: tb/rxq_index_mgr_bench.sv
`timescale 1ns/1ps
module rxq_index_mgr_bench;
  localparam int IDX_W = 7, DEPTH_W = 5, SIZE_W = 7, DADDR_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cfg_mode, cfg_we_start, cfg_we_depth, cfg_we_size;
  logic [IDX_W-1:0] cfg_start_in;
  logic [DEPTH_W-1:0] cfg_depth_in;
  logic [SIZE_W-1:0] cfg_size_in;
  logic [DADDR_W-1:0] data_base;
  logic frm_valid, slot_has_mb, filt_accept, pop_req, ovf_clr;
  logic [IDX_W-1:0] cfg_start, hdr_addr, rd_hdr_idx;
  logic [DEPTH_W-1:0] cfg_depth, entry_cnt;
  logic [SIZE_W-1:0] cfg_size;
  logic [DADDR_W-1:0] data_addr;
  logic cfg_err, hdr_we, stat_we, empty, full, nempty_irq, overflow;

  // second, idle instance (other channel)
  logic [IDX_W-1:0] b_cfg_start, b_hdr_addr, b_rd_hdr_idx;
  logic [DEPTH_W-1:0] b_cfg_depth, b_entry_cnt;
  logic [SIZE_W-1:0] b_cfg_size;
  logic [DADDR_W-1:0] b_data_addr;
  logic b_cfg_err, b_hdr_we, b_stat_we, b_empty, b_full, b_nempty_irq, b_overflow;

  rxq_index_mgr #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W), .DADDR_W(DADDR_W)) u_rxq_index_mgr (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we_start(cfg_we_start),
    .cfg_we_depth(cfg_we_depth), .cfg_we_size(cfg_we_size), .cfg_start_in(cfg_start_in),
    .cfg_depth_in(cfg_depth_in), .cfg_size_in(cfg_size_in), .data_base(data_base),
    .frm_valid(frm_valid), .slot_has_mb(slot_has_mb), .filt_accept(filt_accept),
    .pop_req(pop_req), .ovf_clr(ovf_clr), .cfg_start(cfg_start), .cfg_depth(cfg_depth),
    .cfg_size(cfg_size), .cfg_err(cfg_err), .hdr_we(hdr_we), .stat_we(stat_we),
    .hdr_addr(hdr_addr), .data_addr(data_addr), .rd_hdr_idx(rd_hdr_idx),
    .entry_cnt(entry_cnt), .empty(empty), .full(full), .nempty_irq(nempty_irq),
    .overflow(overflow)
  );

  rxq_index_mgr #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W), .DADDR_W(DADDR_W)) u_rxq_index_mgr_b (
    .clk(clk), .rst(rst), .cfg_mode(1'b0), .cfg_we_start(1'b0),
    .cfg_we_depth(1'b0), .cfg_we_size(1'b0), .cfg_start_in('0),
    .cfg_depth_in('0), .cfg_size_in('0), .data_base('0),
    .frm_valid(1'b0), .slot_has_mb(1'b0), .filt_accept(1'b0),
    .pop_req(1'b0), .ovf_clr(1'b0), .cfg_start(b_cfg_start), .cfg_depth(b_cfg_depth),
    .cfg_size(b_cfg_size), .cfg_err(b_cfg_err), .hdr_we(b_hdr_we), .stat_we(b_stat_we),
    .hdr_addr(b_hdr_addr), .data_addr(b_data_addr), .rd_hdr_idx(b_rd_hdr_idx),
    .entry_cnt(b_entry_cnt), .empty(b_empty), .full(b_full), .nempty_irq(b_nempty_irq),
    .overflow(b_overflow)
  );

  int n_chk = 0, n_fail = 0, b_we_seen = 0;
  bit done = 0;
  always @(posedge clk) if (b_hdr_we) b_we_seen++;

  // reference model state
  int m_start, m_depth, m_size, m_wr, m_rd, m_cnt;
  int m_base = 'h100;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic configure(input int st, input int dp, input int sz);
    cfg_mode = 1; cfg_we_start = 1; cfg_we_depth = 1; cfg_we_size = 1;
    cfg_start_in = IDX_W'(st); cfg_depth_in = DEPTH_W'(dp); cfg_size_in = SIZE_W'(sz);
    @(negedge clk);
    cfg_we_start = 0; cfg_we_depth = 0; cfg_we_size = 0; cfg_mode = 0;
    m_start = st; m_depth = dp; m_size = sz; m_wr = 0; m_rd = 0; m_cnt = 0;
  endtask

  // present one frame, return the strobe seen one edge later
  task automatic frame(input bit mb, input bit acc, input bit pop, output bit we);
    frm_valid = 1; slot_has_mb = mb; filt_accept = acc; pop_req = pop;
    @(negedge clk);
    we = hdr_we;
    frm_valid = 0; slot_has_mb = 0; filt_accept = 0; pop_req = 0;
  endtask

  task automatic append_ok(input string req, input bit pop);
    bit we;
    int eh, ed;
    eh = (m_start + m_wr) % (1 << IDX_W);
    ed = (m_base + m_wr * m_size) % (1 << DADDR_W);
    frame(0, 1, pop, we);
    m_wr = (m_wr == m_depth - 1) ? 0 : m_wr + 1;
    if (pop) m_rd = (m_rd == m_depth - 1) ? 0 : m_rd + 1;
    else m_cnt++;
    chk(req, "hdr_we", 32'(we), 1);
    chk(req, "stat_we", 32'(stat_we), 1);
    chk(req, "hdr_addr", 32'(hdr_addr), eh);
    chk(req, "data_addr", 32'(data_addr), ed);
    chk(req, "entry_cnt", 32'(entry_cnt), m_cnt);
  endtask

  task automatic pop_one(input string req);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    if (m_cnt > 0) begin
      m_rd = (m_rd == m_depth - 1) ? 0 : m_rd + 1;
      m_cnt--;
    end
    chk(req, "rd_hdr_idx", 32'(rd_hdr_idx), (m_start + m_rd) % (1 << IDX_W));
    chk(req, "entry_cnt", 32'(entry_cnt), m_cnt);
  endtask

  task automatic t_reset();
    chk("R10", "entry_cnt", 32'(entry_cnt), 0);
    chk("R10", "empty", 32'(empty), 1);
    chk("R10", "overflow", 32'(overflow), 0);
    chk("R10", "hdr_we", 32'(hdr_we), 0);
    chk("R10", "cfg_depth", 32'(cfg_depth), 0);
    chk("R2", "cfg_err after reset", 32'(cfg_err), 1);
  endtask

  task automatic t_cfg_lock();
    cfg_we_start = 1; cfg_we_depth = 1; cfg_start_in = 5; cfg_depth_in = 6;
    @(negedge clk);
    cfg_we_start = 0; cfg_we_depth = 0;
    chk("R1", "start ignored", 32'(cfg_start), 0);
    chk("R1", "depth ignored", 32'(cfg_depth), 0);
    configure(10, 4, 8);
    chk("R1", "start written", 32'(cfg_start), 10);
    chk("R1", "depth written", 32'(cfg_depth), 4);
    chk("R1", "size written", 32'(cfg_size), 8);
    chk("R2", "cfg_err clear", 32'(cfg_err), 0);
  endtask

  task automatic t_depth_err();
    bit we;
    configure(10, 1, 8);
    chk("R2", "cfg_err depth 1", 32'(cfg_err), 1);
    frame(0, 1, 0, we);
    chk("R2", "no append", 32'(we), 0);
    chk("R2", "count", 32'(entry_cnt), 0);
    configure(10, 4, 8);
  endtask

  task automatic t_filter();
    bit we;
    frame(1, 1, 0, we);
    chk("R3", "dedicated buffer", 32'(we), 0);
    frame(0, 0, 0, we);
    chk("R3", "filter reject", 32'(we), 0);
    filt_accept = 1;
    @(negedge clk);
    filt_accept = 0;
    chk("R3", "no frm_valid", 32'(hdr_we), 0);
    chk("R3", "count", 32'(entry_cnt), 0);
  endtask

  task automatic t_append_wrap();
    for (int i = 0; i < 4; i++) append_ok("R4", 0);
    chk("R9", "full", 32'(full), 1);
    chk("R9", "nempty_irq", 32'(nempty_irq), 1);
    pop_one("R6");
    append_ok("R5", 0);
  endtask

  task automatic t_overflow();
    bit we;
    frame(0, 1, 0, we);
    chk("R7", "no strobe", 32'(we), 0);
    chk("R7", "overflow set", 32'(overflow), 1);
    chk("R7", "count", 32'(entry_cnt), 4);
    @(negedge clk);
    chk("R7", "overflow sticky", 32'(overflow), 1);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    chk("R7", "overflow cleared", 32'(overflow), 0);
    ovf_clr = 1;
    frame(0, 1, 0, we);
    ovf_clr = 0;
    chk("R7", "set wins", 32'(overflow), 1);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
  endtask

  task automatic t_pop();
    for (int i = 0; i < 4; i++) pop_one("R6");
    chk("R9", "empty", 32'(empty), 1);
    chk("R9", "nempty_irq", 32'(nempty_irq), 0);
    pop_one("R6");
  endtask

  task automatic t_simul();
    append_ok("R12", 0);
    append_ok("R12", 0);
    append_ok("R12", 1);
    chk("R12", "rd_hdr_idx", 32'(rd_hdr_idx), (m_start + m_rd) % (1 << IDX_W));
  endtask

  task automatic t_cfg_clear();
    bit we;
    cfg_mode = 1;
    @(negedge clk);
    chk("R8", "count cleared", 32'(entry_cnt), 0);
    chk("R8", "empty", 32'(empty), 1);
    frame(0, 1, 0, we);
    chk("R8", "no append in config", 32'(we), 0);
    cfg_mode = 0;
    configure(100, 3, 5);
    m_base = 'h2F0;
    data_base = DADDR_W'(m_base);
    for (int i = 0; i < 3; i++) append_ok("R8", 0);
    pop_one("R5");
    append_ok("R5", 0);
  endtask

  task automatic t_indep();
    chk("R11", "b count", 32'(b_entry_cnt), 0);
    chk("R11", "b empty", 32'(b_empty), 1);
    chk("R11", "b depth", 32'(b_cfg_depth), 0);
    chk("R11", "b cfg_err", 32'(b_cfg_err), 1);
    chk("R11", "b strobes", b_we_seen, 0);
  endtask

  initial begin
    rst = 1; cfg_mode = 0; cfg_we_start = 0; cfg_we_depth = 0; cfg_we_size = 0;
    cfg_start_in = '0; cfg_depth_in = '0; cfg_size_in = '0; data_base = 16'h100;
    frm_valid = 0; slot_has_mb = 0; filt_accept = 0; pop_req = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfg_lock();
    t_depth_err();
    t_filter();
    t_append_wrap();
    t_overflow();
    t_pop();
    t_simul();
    t_cfg_clear();
    t_indep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule